// File: doc/BRIEF.md
# UART Channel Mode Router

This block sits between a UART channel's serializer, its deserializer and the two serial pins. A two-bit mode input picks one of four channel modes, and the router steers signals to match. It selects what drives the transmit pin and what the receiver listens to. It chooses which bit-rate strobe each side runs from. It also gates the receive data and error flags going to the CPU, the parity and framing check enables, the transmitter status flags, and the CPU's write strobe into the transmitter.

In the two echo modes the router re-times the incoming line itself. On each receiver sampling strobe it captures the received bit and drives the transmit pin with it for the next bit time. A detected break is held on the pin until the receiver reports a valid start bit.

A mode change acts in the same cycle, even in the middle of a character, with one exception. If an echo mode is left just after the receiver has sampled a stop bit, and the transmitter is enabled, the echoed stop bit is completed first.

Top module: `uart_chan_router`

## Requirements
- R1: Mode code 2'b00 is normal. `txd` follows `tx_ser_in`, `rx_line_out` follows `rx_pin`, the transmitter strobe is `tx_baud_en` and the receiver strobe is `rx_baud_en`. All CPU-side and status signals pass through unchanged, and both check enables are 1.
- R2: Mode 2'b01 (automatic echo) and mode 2'b11 (remote loopback) drive `txd` from a one-bit echo register. The register captures `rx_pin` on a cycle with `rx_smp_stb`=1, and the captured value appears on `txd` from the next cycle until the next strobe. The register resets to 1, so an idle echo path drives `txd` high.
- R3: In mode 2'b01, `tx_clk_en_out` follows `rx_baud_en` and `tx_rdy_out`/`tx_emt_out` are 0. `cpu_tx_wr_out` is 0 whatever `cpu_tx_wr_in` is. Receive data valid, error flags and both check enables still pass as in normal mode.
- R4: In mode 2'b10 (local loopback), `txd` is 1 and `rx_line_out` follows `tx_ser_in`, so `rx_pin` has no effect. `rx_clk_en_out` follows `tx_baud_en`. All CPU-side and status signals pass through.
- R5: In mode 2'b11, `tx_clk_en_out` follows `rx_baud_en`. `rx_dat_vld_out` and every bit of `rx_err_out` are 0, and `par_chk_en` and `frm_chk_en` are 0.
- R6: In an echo mode, a cycle with `rx_break_det`=1 forces `txd` to 0 from the next cycle, regardless of strobes. The next cycle with `rx_start_ok`=1 releases it. When both arrive in the same cycle, the release wins.
- R7: Apart from R8, a change on `mode` alters every routed output in the same cycle, with no clock edge needed.
- R8: An echo mode can be left while the stop window is open. The window opens in the cycle where `rx_smp_stb` and `rx_stop_smp` are both 1 and closes at the next `rx_smp_stb`. If `tx_enabled`=1 when the mode is left, `txd` stays on the echo register until that next strobe. With `tx_enabled`=0, `txd` switches at once.
- R9: After reset, with `mode`=2'b01 and no strobes, `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Channel mode code |
| rx_pin | input | 1 | Serial receive pin |
| txd | output | 1 | Serial transmit pin |
| tx_ser_in | input | 1 | Serializer output bit |
| rx_line_out | output | 1 | Line into the deserializer |
| tx_baud_en | input | 1 | Transmit bit-rate strobe |
| rx_baud_en | input | 1 | Receive bit-rate strobe |
| tx_clk_en_out | output | 1 | Strobe given to the serializer |
| rx_clk_en_out | output | 1 | Strobe given to the deserializer |
| rx_smp_stb | input | 1 | Deserializer took a bit sample |
| rx_stop_smp | input | 1 | That sample was a stop bit |
| rx_break_det | input | 1 | Deserializer detected a break |
| rx_start_ok | input | 1 | Deserializer validated a start bit |
| tx_enabled | input | 1 | Transmitter is enabled |
| rx_dat_vld_in | input | 1 | Received character ready |
| rx_err_in | input | ERR_W | Receive error flags |
| rx_dat_vld_out | output | 1 | Received character ready, to CPU |
| rx_err_out | output | ERR_W | Receive error flags, to CPU |
| par_chk_en | output | 1 | Parity check enable to deserializer |
| frm_chk_en | output | 1 | Framing check enable to deserializer |
| cpu_tx_wr_in | input | 1 | CPU write into transmit holding |
| cpu_tx_wr_out | output | 1 | Gated CPU write to serializer |
| tx_rdy_in | input | 1 | Transmit holding empty flag |
| tx_emt_in | input | 1 | Transmitter fully empty flag |
| tx_rdy_out | output | 1 | Reported holding-empty flag |
| tx_emt_out | output | 1 | Reported fully-empty flag |

## Verification
Two pairs of events can land in the same cycle. The first is a mode change out of echo together with the stop-bit sample. The bench drives both in one cycle and expects `txd` to keep showing the echo register: the old bit in that cycle, then the stop bit until the next strobe. The second is a break and a valid start arriving together. That case is provoked with the break hold clear, and judged by `txd` still following the echo register in the next cycle.

// File: rtl/uart_route_pkg.sv
package uart_route_pkg;

  typedef enum logic [1:0] {
    CM_NORMAL      = 2'b00,
    CM_AUTO_ECHO   = 2'b01,
    CM_LOCAL_LOOP  = 2'b10,
    CM_REMOTE_LOOP = 2'b11
  } chan_mode_e;

  typedef struct packed {
    logic echo;        // txd from re-timed receive line
    logic local_lp;    // serializer feeds deserializer
    logic rx_clk_tx;   // receiver runs off transmit strobe
    logic tx_clk_rx;   // transmitter runs off receive strobe
    logic cpu_rx_on;   // receive data/errors reach CPU
    logic chk_on;      // parity/framing checks active
    logic tx_stat_on;  // transmitter status reported
    logic cpu_tx_on;   // CPU writes reach transmitter
  } route_ctl_t;

  function automatic logic mode_echoes(chan_mode_e m);
    return (m == CM_AUTO_ECHO) || (m == CM_REMOTE_LOOP);
  endfunction

  function automatic route_ctl_t decode_mode(chan_mode_e m);
    route_ctl_t c;
    c.echo       = mode_echoes(m);
    c.local_lp   = (m == CM_LOCAL_LOOP);
    c.rx_clk_tx  = (m == CM_LOCAL_LOOP);
    c.tx_clk_rx  = mode_echoes(m);
    c.cpu_rx_on  = (m != CM_REMOTE_LOOP);
    c.chk_on     = (m != CM_REMOTE_LOOP);
    c.tx_stat_on = (m != CM_AUTO_ECHO);
    c.cpu_tx_on  = (m != CM_AUTO_ECHO);
    return c;
  endfunction

endpackage

// File: rtl/uart_mode_decode.sv
module uart_mode_decode
  import uart_route_pkg::*;
(
  input  logic [1:0]  mode_i,
  output route_ctl_t  ctl_o
);

  chan_mode_e mode_e;

  always_comb begin
    mode_e = chan_mode_e'(mode_i);
    ctl_o  = decode_mode(mode_e);
  end

  always_comb begin
    assert_exclusive_R1: assert (!(ctl_o.echo && ctl_o.local_lp));
  end

endmodule

// File: rtl/uart_echo_retimer.sv
module uart_echo_retimer #(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic smp_stb_i,
  input  logic rx_bit_i,
  input  logic brk_det_i,
  input  logic start_ok_i,
  output logic echo_bit_o,
  output logic brk_hold_o
);

  logic bit_q;
  logic brk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= IDLE_LVL;
    end else if (smp_stb_i) begin
      bit_q <= rx_bit_i;
    end
  end

  // release wins over a same-cycle break
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_q <= 1'b0;
    end else if (start_ok_i) begin
      brk_q <= 1'b0;
    end else if (brk_det_i && active_i) begin
      brk_q <= 1'b1;
    end
  end

  assign brk_hold_o = brk_q;
  assign echo_bit_o = brk_q ? 1'b0 : bit_q;

  assert_break_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && brk_det_i && !start_ok_i) |=> (echo_bit_o == 1'b0));

  assert_start_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok_i |=> !brk_hold_o);

  assert_retime_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb_i && !brk_det_i && !brk_hold_o) |=> (echo_bit_o == $past(rx_bit_i)));

endmodule

// File: rtl/uart_echo_exit.sv
module uart_echo_exit (
  input  logic clk,
  input  logic rst_n,
  input  logic echo_mode_i,
  input  logic tx_en_i,
  input  logic smp_stb_i,
  input  logic stop_smp_i,
  output logic echo_sel_o,
  output logic hold_o
);

  logic stop_win_q;
  logic echo_prev_q;
  logic linger_q;
  logic stop_begin;
  logic win_open;
  logic hold_c;
  logic linger_n;

  assign stop_begin = smp_stb_i && stop_smp_i;
  assign win_open   = stop_win_q || stop_begin;
  assign hold_c     = tx_en_i && !echo_mode_i && (echo_prev_q || linger_q) && win_open;
  assign linger_n   = tx_en_i && !echo_mode_i && (echo_prev_q || linger_q)
                      && (stop_begin || (stop_win_q && !smp_stb_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_win_q  <= 1'b0;
      echo_prev_q <= 1'b0;
      linger_q    <= 1'b0;
    end else begin
      if (stop_begin) begin
        stop_win_q <= 1'b1;
      end else if (smp_stb_i) begin
        stop_win_q <= 1'b0;
      end
      echo_prev_q <= echo_mode_i;
      linger_q    <= linger_n;
    end
  end

  assign hold_o     = hold_c;
  assign echo_sel_o = echo_mode_i || hold_c;

  assert_hold_ends_on_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb_i && !stop_smp_i) |=> !linger_q);

  assert_no_hold_without_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en_i |-> !hold_o);

endmodule

// File: rtl/uart_chan_router.sv
module uart_chan_router
  import uart_route_pkg::*;
#(
  parameter int ERR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             rx_pin,
  output logic             txd,
  input  logic             tx_ser_in,
  output logic             rx_line_out,
  input  logic             tx_baud_en,
  input  logic             rx_baud_en,
  output logic             tx_clk_en_out,
  output logic             rx_clk_en_out,
  input  logic             rx_smp_stb,
  input  logic             rx_stop_smp,
  input  logic             rx_break_det,
  input  logic             rx_start_ok,
  input  logic             tx_enabled,
  input  logic             rx_dat_vld_in,
  input  logic [ERR_W-1:0] rx_err_in,
  output logic             rx_dat_vld_out,
  output logic [ERR_W-1:0] rx_err_out,
  output logic             par_chk_en,
  output logic             frm_chk_en,
  input  logic             cpu_tx_wr_in,
  output logic             cpu_tx_wr_out,
  input  logic             tx_rdy_in,
  input  logic             tx_emt_in,
  output logic             tx_rdy_out,
  output logic             tx_emt_out
);

  route_ctl_t ctl;
  logic       echo_bit;
  logic       brk_hold;
  logic       echo_sel;
  logic       exit_hold;

  uart_mode_decode u_dec (
    .mode_i (mode),
    .ctl_o  (ctl)
  );

  uart_echo_retimer #(.IDLE_LVL(1'b1)) u_retime (
    .clk        (clk),
    .rst_n      (rst_n),
    .active_i   (ctl.echo),
    .smp_stb_i  (rx_smp_stb),
    .rx_bit_i   (rx_pin),
    .brk_det_i  (rx_break_det),
    .start_ok_i (rx_start_ok),
    .echo_bit_o (echo_bit),
    .brk_hold_o (brk_hold)
  );

  uart_echo_exit u_exit (
    .clk         (clk),
    .rst_n       (rst_n),
    .echo_mode_i (ctl.echo),
    .tx_en_i     (tx_enabled),
    .smp_stb_i   (rx_smp_stb),
    .stop_smp_i  (rx_stop_smp),
    .echo_sel_o  (echo_sel),
    .hold_o      (exit_hold)
  );

  always_comb begin
    if (echo_sel)          txd = echo_bit;
    else if (ctl.local_lp) txd = 1'b1;
    else                   txd = tx_ser_in;
  end

  assign rx_line_out    = ctl.local_lp ? tx_ser_in : rx_pin;
  assign tx_clk_en_out  = ctl.tx_clk_rx ? rx_baud_en : tx_baud_en;
  assign rx_clk_en_out  = ctl.rx_clk_tx ? tx_baud_en : rx_baud_en;
  assign rx_dat_vld_out = rx_dat_vld_in & ctl.cpu_rx_on;
  assign rx_err_out     = rx_err_in & {ERR_W{ctl.cpu_rx_on}};
  assign par_chk_en     = ctl.chk_on;
  assign frm_chk_en     = ctl.chk_on;
  assign cpu_tx_wr_out  = cpu_tx_wr_in & ctl.cpu_tx_on;
  assign tx_rdy_out     = tx_rdy_in & ctl.tx_stat_on;
  assign tx_emt_out     = tx_emt_in & ctl.tx_stat_on;

  assert_local_txd_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && !exit_hold) |-> txd);

  assert_local_loop_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |-> (rx_line_out == tx_ser_in));

  assert_remote_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |-> (!rx_dat_vld_out && rx_err_out == '0 && !par_chk_en));

  assert_auto_status_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> (!tx_rdy_out && !tx_emt_out && !cpu_tx_wr_out));

  assert_normal_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && !exit_hold) |-> (txd == tx_ser_in && rx_line_out == rx_pin));

endmodule

// File: tb/tb_uart_chan_router.sv
module tb_uart_chan_router;

  localparam int EW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic rx_pin = 1'b1, tx_ser_in = 1'b1;
  logic tx_baud_en = 1'b0, rx_baud_en = 1'b0;
  logic rx_smp_stb = 1'b0, rx_stop_smp = 1'b0, rx_break_det = 1'b0, rx_start_ok = 1'b0;
  logic tx_enabled = 1'b0, rx_dat_vld_in = 1'b0, cpu_tx_wr_in = 1'b0;
  logic tx_rdy_in = 1'b0, tx_emt_in = 1'b0;
  logic [EW-1:0] rx_err_in = '0;
  logic txd, rx_line_out, tx_clk_en_out, rx_clk_en_out, rx_dat_vld_out;
  logic par_chk_en, frm_chk_en, cpu_tx_wr_out, tx_rdy_out, tx_emt_out;
  logic [EW-1:0] rx_err_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_chan_router #(.ERR_W(EW)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rx_pin(rx_pin), .txd(txd),
    .tx_ser_in(tx_ser_in), .rx_line_out(rx_line_out),
    .tx_baud_en(tx_baud_en), .rx_baud_en(rx_baud_en),
    .tx_clk_en_out(tx_clk_en_out), .rx_clk_en_out(rx_clk_en_out),
    .rx_smp_stb(rx_smp_stb), .rx_stop_smp(rx_stop_smp),
    .rx_break_det(rx_break_det), .rx_start_ok(rx_start_ok),
    .tx_enabled(tx_enabled), .rx_dat_vld_in(rx_dat_vld_in), .rx_err_in(rx_err_in),
    .rx_dat_vld_out(rx_dat_vld_out), .rx_err_out(rx_err_out),
    .par_chk_en(par_chk_en), .frm_chk_en(frm_chk_en),
    .cpu_tx_wr_in(cpu_tx_wr_in), .cpu_tx_wr_out(cpu_tx_wr_out),
    .tx_rdy_in(tx_rdy_in), .tx_emt_in(tx_emt_in),
    .tx_rdy_out(tx_rdy_out), .tx_emt_out(tx_emt_out)
  );

  task automatic check(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  // advance one edge; inputs change and outputs are sampled 1ns after it
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic strobe(input logic bitv, input logic stop);
    rx_pin = bitv; rx_smp_stb = 1'b1; rx_stop_smp = stop;
    tick();
    rx_smp_stb = 1'b0; rx_stop_smp = 1'b0;
    settle();
  endtask

  task automatic t_reset();
    mode = 2'b01; rx_pin = 1'b0; tx_ser_in = 1'b0;
    settle();
    check("R9", "txd idle after reset", {7'd0, txd}, 8'h01);
  endtask

  task automatic t_normal();
    mode = 2'b00; tx_enabled = 1'b0;
    tx_ser_in = 1'b0; rx_pin = 1'b1; tx_baud_en = 1'b1; rx_baud_en = 1'b0;
    rx_dat_vld_in = 1'b1; rx_err_in = 3'b101; cpu_tx_wr_in = 1'b1; tx_rdy_in = 1'b1; tx_emt_in = 1'b1;
    settle();
    check("R1", "txd", {7'd0, txd}, 8'h00);
    check("R1", "rx_line", {7'd0, rx_line_out}, 8'h01);
    check("R1", "clk en pair", {6'd0, tx_clk_en_out, rx_clk_en_out}, 8'h02);
    check("R1", "cpu/status", {3'd0, rx_dat_vld_out, cpu_tx_wr_out, tx_rdy_out, tx_emt_out, par_chk_en & frm_chk_en}, 8'h1f);
    check("R1", "err", {5'd0, rx_err_out}, 8'h05);
    tx_ser_in = 1'b1; rx_pin = 1'b0;
    settle();
    check("R1", "txd follows ser", {6'd0, txd, rx_line_out}, 8'h02);
  endtask

  task automatic t_auto_echo();
    mode = 2'b01; tx_ser_in = 1'b1;
    settle();
    check("R7", "txd switched at once to echo reg", {7'd0, txd}, 8'h01);
    check("R3", "status forced off", {5'd0, tx_rdy_out, tx_emt_out, cpu_tx_wr_out}, 8'h00);
    check("R3", "rx side alive", {5'd0, rx_dat_vld_out, par_chk_en, frm_chk_en}, 8'h07);
    tx_baud_en = 1'b0; rx_baud_en = 1'b1;
    settle();
    check("R3", "tx clk from rx strobe", {7'd0, tx_clk_en_out}, 8'h01);
    strobe(1'b0, 1'b0);
    check("R2", "retimed 0", {7'd0, txd}, 8'h00);
    rx_pin = 1'b1;
    tick();
    check("R2", "held between strobes", {7'd0, txd}, 8'h00);
    strobe(1'b1, 1'b0);
    check("R2", "retimed 1", {7'd0, txd}, 8'h01);
  endtask

  task automatic t_local();
    mode = 2'b10; tx_ser_in = 1'b0; rx_pin = 1'b1; tx_baud_en = 1'b1; rx_baud_en = 1'b0;
    settle();
    check("R4", "txd high", {7'd0, txd}, 8'h01);
    check("R4", "rx line from ser", {7'd0, rx_line_out}, 8'h00);
    check("R4", "rx clk from tx strobe", {7'd0, rx_clk_en_out}, 8'h01);
    rx_pin = 1'b0; tx_ser_in = 1'b1;
    settle();
    check("R4", "rx_pin ignored", {6'd0, rx_line_out, txd}, 8'h03);
    check("R4", "status passes", {4'd0, rx_dat_vld_out, tx_rdy_out, cpu_tx_wr_out, par_chk_en}, 8'h0f);
  endtask

  task automatic t_remote();
    mode = 2'b11; tx_baud_en = 1'b0; rx_baud_en = 1'b1;
    settle();
    check("R5", "cpu rx blocked", {4'd0, rx_dat_vld_out, rx_err_out}, 8'h00);
    check("R5", "checks off", {6'd0, par_chk_en, frm_chk_en}, 8'h00);
    check("R5", "tx clk from rx", {7'd0, tx_clk_en_out}, 8'h01);
    strobe(1'b0, 1'b0);
    check("R2", "remote retimed 0", {7'd0, txd}, 8'h00);
    strobe(1'b1, 1'b0);
    check("R2", "remote retimed 1", {7'd0, txd}, 8'h01);
  endtask

  task automatic t_break();
    mode = 2'b01; rx_break_det = 1'b1;
    tick();
    rx_break_det = 1'b0;
    settle();
    check("R6", "break forces 0", {7'd0, txd}, 8'h00);
    strobe(1'b1, 1'b0);
    check("R6", "break held over strobe", {7'd0, txd}, 8'h00);
    rx_start_ok = 1'b1;
    tick();
    rx_start_ok = 1'b0;
    settle();
    check("R6", "start releases", {7'd0, txd}, 8'h01);
    rx_break_det = 1'b1; rx_start_ok = 1'b1;
    tick();
    rx_break_det = 1'b0; rx_start_ok = 1'b0;
    settle();
    check("R6", "same-cycle release wins", {7'd0, txd}, 8'h01);
  endtask

  task automatic t_exit_linger();
    mode = 2'b01; tx_enabled = 1'b1; tx_ser_in = 1'b0;
    strobe(1'b1, 1'b1);
    mode = 2'b00;
    settle();
    check("R8", "stop held after exit", {7'd0, txd}, 8'h01);
    tick(); tick();
    check("R8", "still held", {7'd0, txd}, 8'h01);
    strobe(1'b0, 1'b0);
    check("R8", "released at next strobe", {7'd0, txd}, 8'h00);
    tx_ser_in = 1'b1;
    settle();
    check("R1", "normal after release", {7'd0, txd}, 8'h01);
  endtask

  task automatic t_exit_no_tx();
    mode = 2'b01; tx_enabled = 1'b0; tx_ser_in = 1'b0;
    strobe(1'b1, 1'b1);
    mode = 2'b00;
    settle();
    check("R8", "no hold without tx enable", {7'd0, txd}, 8'h00);
    strobe(1'b1, 1'b0);
  endtask

  task automatic t_exit_same_cycle();
    mode = 2'b01; tx_enabled = 1'b1; tx_ser_in = 1'b1;
    strobe(1'b0, 1'b0);
    rx_pin = 1'b1; rx_smp_stb = 1'b1; rx_stop_smp = 1'b1; mode = 2'b00;
    settle();
    check("R8", "same cycle keeps old echo bit", {7'd0, txd}, 8'h00);
    tick();
    rx_smp_stb = 1'b0; rx_stop_smp = 1'b0; tx_ser_in = 1'b0;
    settle();
    check("R8", "stop echoed after same-cycle exit", {7'd0, txd}, 8'h01);
    strobe(1'b1, 1'b0);
    check("R8", "normal after window", {7'd0, txd}, 8'h00);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #3;
    tick(); tick();
    rst_n = 1'b1;
    settle();
    t_reset();
    t_normal();
    t_auto_echo();
    t_local();
    t_remote();
    t_break();
    t_exit_linger();
    t_exit_no_tx();
    t_exit_same_cycle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule